// File: doc/BRIEF.md
# Command Mailbox Port (Device Side)

This block is the device end of a byte-wide host port that carries command and response packets between a host processor and an internal coprocessor. The host sees two registers behind a single address bit. Address 0 is the data register. Address 1 returns status on reads and accepts command codes on writes. On the core side, command bytes leave as a valid/ready stream. Response bytes arrive as a valid/ready stream whose last byte is flagged.

A transaction runs as follows:

1. The host opens a packet with an open code.
2. The host writes payload bytes one at a time, pacing itself on an input-full flag.
3. The host closes the packet with a close code. This notifies the core.
4. The port returns the response framed by two control bytes: a leading 0x01 and a trailing 0x03. Each control byte is flagged by a dedicated status bit, so the host can tell it apart from payload.
5. When the trailing marker has been read, the port is ready again.

An abort code may be written at any moment. It drops whatever is in flight and returns the port to the ready state.

Top module: `cmd_mailbox_port`

## Requirements
- R1: After reset, the status register reads 0x10 (only the ready bit set), cmd_valid is low and rsp_ready is low.
- R2: Status bit positions are fixed: bit 0 output-full, bit 1 input-full, bit 2 control-byte flag, bit 3 last-write-was-command, bit 4 ready-for-command, bit 5 ready-for-data, bits 7:6 zero. Bit 3 sets on any write to address 1 and clears on any write to address 0.
- R3: Writing 0x01 to address 1 while ready opens a packet. From the next cycle the ready bit is clear and the ready-for-data bit is set.
- R4: A data write while a packet is open and input-full is clear does two things. It sets input-full. It presents the byte on cmd_data with cmd_valid high. Input-full and cmd_valid clear in the cycle after a cmd_valid/cmd_ready handshake.
- R5: Data writes are ignored in two cases: when no packet is open, and while input-full is set. In both cases cmd_valid and cmd_data keep their values.
- R6: Writing 0x03 while a packet is open and input-full is clear closes the packet. In the next cycle ready-for-data is clear and cmd_done is high for exactly one cycle. A 0x03 written while input-full is set is ignored.
- R7: Closing a packet loads 0x01 into the data register with output-full and the control flag set. A host read of address 0 returns that byte and clears both bits.
- R8: rsp_ready is high only in the payload phase while output-full is clear. An accepted response byte appears in the data register in the next cycle, with output-full set and the control flag clear.
- R9: After the host reads the byte flagged rsp_last, the port presents 0x03 with output-full and the control flag set. Reading that byte returns the port to ready.
- R10: Writing 0x22 to address 1 in any phase aborts. In the next cycle the port is ready, with output-full, input-full, the control flag and ready-for-data clear, and cmd_valid low. cmd_abort is high for exactly one cycle.
- R11: Command codes other than 0x01, 0x03 and 0x22, and a 0x01 written while a packet is open, leave the framing state unchanged (only bit 3 changes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | Register select: 0 data, 1 status/command |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from address) |
| cmd_valid | output | 1 | Command byte available to the core |
| cmd_ready | input | 1 | Core accepts the command byte |
| cmd_data | output | 8 | Command byte |
| cmd_done | output | 1 | One-cycle pulse when a packet is closed |
| cmd_abort | output | 1 | One-cycle pulse on abort |
| rsp_valid | input | 1 | Core offers a response byte |
| rsp_ready | output | 1 | Port accepts a response byte |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |

## Verification
Register updates have a latency of one clock edge:

- A host write or read strobe takes effect in the status, cmd_valid, cmd_done and cmd_abort values of the following cycle.
- A response handshake shows up in the data register one cycle later.
- The trailing marker needs one more cycle after the last payload byte has been read.

host_rdata and rsp_ready are combinational, so they reflect the current cycle.

The directed tasks hold each strobe from one falling edge to the next, so exactly one rising edge falls inside it. They then sample at the following falling edge, or 1 ns after a falling edge for combinational outputs. Every expected value is therefore read exactly one edge after its cause. The one-cycle pulses are checked twice: high directly after the causing write, and low one cycle later.

// File: rtl/cmd_mailbox_port.sv
module cmd_mailbox_port #(
  parameter logic [7:0] OPEN_CODE  = 8'h01,
  parameter logic [7:0] CLOSE_CODE = 8'h03,
  parameter logic [7:0] ABORT_CODE = 8'h22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_data,
  output logic       cmd_done,
  output logic       cmd_abort,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic [7:0] rsp_data,
  input  logic       rsp_last
);

  typedef enum logic [2:0] {ST_IDLE, ST_RECV, ST_PAY, ST_TAIL, ST_DRAIN} st_t;

  st_t        state;
  logic       obf, ibf, f0, a2;
  logic [7:0] dout;
  logic       rdy, ibr;

  wire wr_cmd = host_wr &  host_addr;
  wire wr_dat = host_wr & ~host_addr;
  wire rd_dat = host_rd & ~host_addr;
  wire abort  = wr_cmd && (host_wdata == ABORT_CODE);

  assign rdy        = (state == ST_IDLE);
  assign ibr        = (state == ST_RECV);
  assign cmd_valid  = ibf;
  assign rsp_ready  = (state == ST_PAY) && !obf;
  assign host_rdata = host_addr ? {2'b00, ibr, rdy, a2, f0, ibf, obf} : dout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      obf       <= 1'b0;
      ibf       <= 1'b0;
      f0        <= 1'b0;
      a2        <= 1'b0;
      dout      <= 8'h00;
      cmd_data  <= 8'h00;
      cmd_done  <= 1'b0;
      cmd_abort <= 1'b0;
    end else begin
      cmd_done  <= 1'b0;
      cmd_abort <= 1'b0;
      if (wr_cmd) a2 <= 1'b1;
      else if (wr_dat) a2 <= 1'b0;

      if (abort) begin
        state     <= ST_IDLE;
        obf       <= 1'b0;
        ibf       <= 1'b0;
        f0        <= 1'b0;
        cmd_abort <= 1'b1;
      end else begin
        if (rd_dat && obf) begin
          obf <= 1'b0;
          f0  <= 1'b0;
        end
        if (ibf && cmd_ready) ibf <= 1'b0;

        case (state)
          ST_IDLE:
            if (wr_cmd && host_wdata == OPEN_CODE) state <= ST_RECV;
          ST_RECV:
            if (wr_dat && !ibf) begin
              ibf      <= 1'b1;
              cmd_data <= host_wdata;
            end else if (wr_cmd && host_wdata == CLOSE_CODE && !ibf) begin
              state    <= ST_PAY;
              cmd_done <= 1'b1;
              obf      <= 1'b1;
              f0       <= 1'b1;
              dout     <= OPEN_CODE;
            end
          ST_PAY:
            if (rsp_valid && rsp_ready) begin
              dout <= rsp_data;
              obf  <= 1'b1;
              f0   <= 1'b0;
              if (rsp_last) state <= ST_TAIL;
            end
          ST_TAIL:
            if (!obf) begin
              dout  <= CLOSE_CODE;
              obf   <= 1'b1;
              f0    <= 1'b1;
              state <= ST_DRAIN;
            end
          ST_DRAIN:
            if (rd_dat && obf) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cmd_mailbox_port_checker.sv
module cmd_mailbox_port_checker #(
  parameter logic [7:0] CLOSE_CODE = 8'h03,
  parameter logic [7:0] ABORT_CODE = 8'h22
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_addr,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       cmd_done,
  input logic       cmd_abort,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       obf,
  input logic       ibf,
  input logic       f0,
  input logic       rdy,
  input logic       ibr,
  input logic [7:0] dout
);

  wire abort_wr = host_wr && host_addr && (host_wdata == ABORT_CODE);

  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !abort_wr |=> cmd_valid && $stable(cmd_data));

  a_r5_idle_data_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !host_addr && !ibr |=> !cmd_valid);

  a_r6_done_follows_close: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(host_wr && host_addr && host_wdata == CLOSE_CODE));

  a_r8_rsp_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !abort_wr |=> obf && !f0 && dout == $past(rsp_data));

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> cmd_abort && rdy && !obf && !ibf && !f0 && !cmd_valid);

endmodule

bind cmd_mailbox_port cmd_mailbox_port_checker #(
  .CLOSE_CODE(CLOSE_CODE),
  .ABORT_CODE(ABORT_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .cmd_done(cmd_done), .cmd_abort(cmd_abort),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .obf(obf), .ibf(ibf), .f0(f0), .rdy(rdy), .ibr(ibr), .dout(dout)
);

// File: tb/cmd_mailbox_port_bench.sv
`timescale 1ns/1ps
module cmd_mailbox_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       cmd_valid, cmd_done, cmd_abort, rsp_ready;
  logic       cmd_ready = 1'b0;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0, rsp_last = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_mailbox_port u_cmd_mailbox_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .cmd_abort(cmd_abort), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(logic a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic core_take(string req, logic [7:0] exp);
    chk({req, " cmd_valid"}, {7'd0, cmd_valid}, 8'h01);
    chk({req, " cmd_data"}, cmd_data, exp);
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    chk({req, " cmd_valid cleared"}, {7'd0, cmd_valid}, 8'h00);
  endtask

  task automatic rsp_give(logic [7:0] d, logic last);
    @(negedge clk); rsp_valid = 1'b1; rsp_data = d; rsp_last = last;
    #1 chk("R8 rsp_ready with OBF clear", {7'd0, rsp_ready}, 8'h01);
    @(negedge clk); rsp_valid = 1'b0; rsp_last = 1'b0;
    #1 chk("R8 rsp_ready low while OBF set", {7'd0, rsp_ready}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    hread(1'b1, s);
    chk("R1 reset status", s, 8'h10);
    chk("R1 reset cmd_valid", {7'd0, cmd_valid}, 8'h00);
    chk("R1 reset rsp_ready", {7'd0, rsp_ready}, 8'h00);
  endtask

  task automatic t_idle_ignore();
    logic [7:0] s;
    hwrite(1'b0, 8'h5A);
    hread(1'b1, s);
    chk("R5 data write while idle", s, 8'h10);
    chk("R5 idle cmd_valid", {7'd0, cmd_valid}, 8'h00);
    hwrite(1'b1, 8'h7E);
    hread(1'b1, s);
    chk("R11/R2 unknown code sets only bit3", s, 8'h18);
    hwrite(1'b0, 8'h11);
    hread(1'b1, s);
    chk("R2 data write clears bit3", s, 8'h10);
  endtask

  task automatic t_packet(logic [7:0] b0, logic [7:0] b1);
    logic [7:0] s;
    hwrite(1'b1, 8'h01);
    hread(1'b1, s);
    chk("R3 open packet", s, 8'h28);
    hwrite(1'b1, 8'h01);
    hread(1'b1, s);
    chk("R11 second open ignored", s, 8'h28);
    hwrite(1'b0, b0);
    hread(1'b1, s);
    chk("R4 IBF set after data write", s, 8'h22);
    hwrite(1'b0, 8'h3C);
    chk("R5 write while IBF set ignored", cmd_data, b0);
    hwrite(1'b1, 8'h03);
    chk("R6 close ignored while IBF set", {7'd0, cmd_done}, 8'h00);
    hread(1'b1, s);
    chk("R6 still receiving", s, 8'h2A);
    core_take("R4", b0);
    hread(1'b1, s);
    chk("R4 IBF cleared", s, 8'h28);
    hwrite(1'b0, b1);
    core_take("R4", b1);
    hwrite(1'b1, 8'h03);
    chk("R6 cmd_done pulse", {7'd0, cmd_done}, 8'h01);
    @(negedge clk);
    chk("R6 cmd_done one cycle", {7'd0, cmd_done}, 8'h00);
    hread(1'b1, s);
    chk("R7 header flagged", s, 8'h0D);
    hread(1'b0, s);
    chk("R7 header byte", s, 8'h01);
    hread(1'b1, s);
    chk("R7 header read clears OBF/F0", s, 8'h08);
  endtask

  task automatic t_response(logic [7:0] p0, logic [7:0] p1);
    logic [7:0] s;
    rsp_give(p0, 1'b0);
    hread(1'b1, s);
    chk("R8 payload status", s, 8'h09);
    hread(1'b0, s);
    chk("R8 payload byte 0", s, p0);
    rsp_give(p1, 1'b1);
    hread(1'b0, s);
    chk("R8 payload byte 1", s, p1);
    hread(1'b1, s);
    chk("R9 trailer flagged", s, 8'h0D);
    hread(1'b0, s);
    chk("R9 trailer byte", s, 8'h03);
    hread(1'b1, s);
    chk("R9 back to ready", s, 8'h18);
  endtask

  task automatic t_cancel_recv();
    logic [7:0] s;
    hwrite(1'b1, 8'h01);
    hwrite(1'b0, 8'h77);
    chk("R10 pre-abort cmd_valid", {7'd0, cmd_valid}, 8'h01);
    hwrite(1'b1, 8'h22);
    chk("R10 cmd_abort pulse", {7'd0, cmd_abort}, 8'h01);
    chk("R10 cmd_valid dropped", {7'd0, cmd_valid}, 8'h00);
    @(negedge clk);
    chk("R10 cmd_abort one cycle", {7'd0, cmd_abort}, 8'h00);
    hread(1'b1, s);
    chk("R10 status after abort in receive", s, 8'h18);
  endtask

  task automatic t_cancel_resp();
    logic [7:0] s;
    t_packet(8'h10, 8'h20);
    rsp_give(8'h99, 1'b0);
    hwrite(1'b1, 8'h22);
    hread(1'b1, s);
    chk("R10 status after abort in response", s, 8'h18);
    chk("R10 rsp_ready low after abort", {7'd0, rsp_ready}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_ignore();
    t_packet(8'hA5, 8'hC3);
    t_response(8'h5E, 8'hE7);
    t_cancel_recv();
    t_cancel_resp();
    t_packet(8'h00, 8'hFF);
    t_response(8'hFF, 8'h00);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule